// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block runs on the host side of a four-wire serial programming link and puts a target device into its serial programming mode. After a start request it pulses the target's reset line high and then holds it low. It waits a settling time derived from the system clock frequency, and then shifts a four-byte enable frame to the target. The frame goes out most significant bit first in SPI mode 0, and the serial clock is divided down from the system clock.

While the third byte is shifted, the block captures the byte that the target returns on its data output. A target that is in step returns the second frame byte, 0x53. The frame is always sent in full, whatever the returned byte is. When the captured byte matches, the block raises its done flag. When it does not match, the block pulses reset again, waits again and resends the frame. After a set number of failed attempts it raises a fail flag and stops. A separate request at the end of the session drives the reset line high, which releases the target into normal operation.

Top module: `prog_entry_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tgt_rst`, `sck`, `mosi`, `done` and `fail` are all low.
- R2: Each attempt begins with `tgt_rst` high for exactly PULSE_CYC system clock cycles, and `sck` stays low for the whole pulse.
- R3: After each reset pulse, `tgt_rst` stays low and `sck` stays low for at least WAIT_CYC = CLK_HZ/1000*WAIT_MS system clock cycles before the first rising edge of `sck`.
- R4: Each attempt shifts exactly four bytes in SPI mode 0, MSB first. The bytes are OP0, 0x53, OP2 and OP3, in that order. `sck` idles low, and `mosi` changes only while `sck` is low.
- R5: The byte read from `miso` on the rising `sck` edges of the third byte is the echo. If the echo equals 0x53, `done` rises after the fourth byte and stays high.
- R6: All four bytes of an attempt are sent even when the echo is wrong, so each attempt produces exactly 32 rising `sck` edges.
- R7: When the echo differs from 0x53 and fewer than MAX_TRIES attempts have been made, a new reset pulse (R2) and wait (R3) follow, and then the frame is resent.
- R8: After MAX_TRIES attempts that all returned a wrong echo, `fail` rises and stays high. No further reset pulse or `sck` edge is produced.
- R9: A pulse on `end_session` while `done` or `fail` is high drives `tgt_rst` high and holds it there, with `sck` low and the flag kept.
- R10: `done` and `fail` are never high together, and `sck` is never high while `tgt_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an entry sequence (accepted when idle or released) |
| end_session | input | 1 | Release the target after done or fail |
| miso | input | 1 | Serial data from target |
| sck | output | 1 | Serial clock to target, idle low |
| mosi | output | 1 | Serial data to target |
| tgt_rst | output | 1 | Target reset pin level (high = reset pulse or release) |
| done | output | 1 | Target answered with the correct echo |
| fail | output | 1 | All attempts failed |

## Verification
The assertions check four rules on every cycle. The done and fail flags are never high together. The serial clock is quiet outside the frame state and while the reset pin is high. `mosi` holds steady while the serial clock is high. Each flag rises only with a matching or mismatching captured echo. The pulse length, the settling gap, the byte values and their order, the attempt count and the silence after failure can only be shown by the bench's scenarios. The bench uses a target model that echoes correctly only after a chosen number of bad attempts, and it sweeps that number from zero up to one past the retry limit.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h53;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_SEND,
    ST_CHECK,
    ST_DONE,
    ST_FAIL,
    ST_REL
  } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CLAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bit_q <= '0;
      tx_q  <= '0;
      rx    <= '0;
      sck   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          tx_q  <= din;
          busy  <= 1'b1;
          cnt_q <= '0;
          bit_q <= '0;
          sck   <= 1'b0;
        end
      end else if (cnt_q == CLAST) begin
        cnt_q <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck  <= 1'b0;
          tx_q <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mosi = tx_q[7];

  // R4: data to the target only moves while the clock is low
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));
endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
  import prog_seq_pkg::*;
#(
  parameter int         CLK_HZ    = 50_000_000,
  parameter int         WAIT_MS   = 20,
  parameter int         PULSE_CYC = 8,
  parameter int         SCK_HALF  = 25,
  parameter int         MAX_TRIES = 4,
  parameter logic [7:0] OP0       = 8'hAC,
  parameter logic [7:0] OP2       = 8'h00,
  parameter logic [7:0] OP3       = 8'h00
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic end_session,
  input  logic miso,
  output logic sck,
  output logic mosi,
  output logic tgt_rst,
  output logic done,
  output logic fail
);
  localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;
  localparam int TMAX     = (WAIT_CYC > PULSE_CYC) ? WAIT_CYC : PULSE_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int NW       = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] WAIT_LD  = TW'(WAIT_CYC - 1);
  localparam logic [NW-1:0] TRY_LAST = NW'(MAX_TRIES - 1);

  seq_state_t    state_q, state_n;
  logic [1:0]    idx_q, idx_n;
  logic [NW-1:0] tries_q;
  logic [7:0]    echo_q;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          sh_start, sh_busy, sh_done;
  logic [7:0]    sh_byte, sh_rx;

  seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .zero(t_zero)
  );

  spi_byte_shift #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .din(sh_byte), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx(sh_rx)
  );

  always_comb begin
    case (idx_n)
      2'd0:    sh_byte = OP0;
      2'd1:    sh_byte = SYNC_BYTE;
      2'd2:    sh_byte = OP2;
      default: sh_byte = OP3;
    endcase
  end

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    t_load   = 1'b0;
    t_val    = PULSE_LD;
    sh_start = 1'b0;
    case (state_q)
      ST_IDLE, ST_REL: if (start) begin
        state_n = ST_PULSE;
        t_load  = 1'b1;
      end
      ST_PULSE: if (t_zero) begin
        state_n = ST_WAIT;
        t_load  = 1'b1;
        t_val   = WAIT_LD;
      end
      ST_WAIT: if (t_zero) begin
        state_n  = ST_SEND;
        idx_n    = 2'd0;
        sh_start = 1'b1;
      end
      ST_SEND: if (sh_done) begin
        if (idx_q == 2'd3) state_n = ST_CHECK;
        else begin
          idx_n    = idx_q + 2'd1;
          sh_start = 1'b1;
        end
      end
      ST_CHECK: begin
        if (echo_q == SYNC_BYTE)     state_n = ST_DONE;
        else if (tries_q == TRY_LAST) state_n = ST_FAIL;
        else begin
          state_n = ST_PULSE;
          t_load  = 1'b1;
        end
      end
      ST_DONE, ST_FAIL: if (end_session) state_n = ST_REL;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tries_q <= '0;
      echo_q  <= '0;
      tgt_rst <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      tgt_rst <= (state_n == ST_PULSE) || (state_n == ST_REL);
      if ((state_q == ST_IDLE || state_q == ST_REL) && start) begin
        tries_q <= '0;
        done    <= 1'b0;
        fail    <= 1'b0;
      end else begin
        if (state_n == ST_DONE) done <= 1'b1;
        if (state_n == ST_FAIL) fail <= 1'b1;
      end
      if (state_q == ST_CHECK && state_n == ST_PULSE) tries_q <= tries_q + 1'b1;
      if (state_q == ST_SEND && sh_done && idx_q == 2'd2) echo_q <= sh_rx;
    end
  end

  // R10: the two result flags exclude each other
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  // R10: clock quiet while reset pin is high
  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    tgt_rst |-> !sck);
  // R4: serial clock only toggles inside the frame state
  a_r4_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SEND) |-> !sck);
  // R4: a new byte is never started over a running one
  a_r4_start_when_free: assert property (@(posedge clk) disable iff (rst)
    sh_start |-> !sh_busy);
  // R5: success only on a matching echo
  a_r5_done_on_match: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (echo_q == SYNC_BYTE));
  // R8: failure only on a mismatching echo, attempt count bounded
  a_r8_fail_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (echo_q != SYNC_BYTE));
  a_r8_tries_bound: assert property (@(posedge clk) disable iff (rst)
    tries_q <= TRY_LAST);
endmodule

// File: tb/tb_prog_entry_seq.sv
module tb_prog_entry_seq;
  localparam int CLK_HZ = 50_000, WAIT_MS = 2, PULSE_CYC = 4, SCK_HALF = 2, MAX_TRIES = 3;
  localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;
  localparam logic [7:0] OP0 = 8'hAC, OP2 = 8'h3C, OP3 = 8'h96;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, end_session = 1'b0, miso = 1'b0;
  logic sck, mosi, tgt_rst, done, fail;
  int checks = 0, errors = 0;

  prog_entry_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS), .PULSE_CYC(PULSE_CYC),
    .SCK_HALF(SCK_HALF), .MAX_TRIES(MAX_TRIES), .OP0(OP0), .OP2(OP2), .OP3(OP3)) dut (
    .clk(clk), .rst(rst), .start(start), .end_session(end_session), .miso(miso),
    .sck(sck), .mosi(mosi), .tgt_rst(tgt_rst), .done(done), .fail(fail));

  always #10 clk = ~clk;

  // pin monitor, sampled on the falling system clock edge
  int pulses, plen, pmin, pmax, gcnt, gmin, rises, viol;
  logic prev_rst, prev_sck, gap_on;
  always @(negedge clk) begin
    if (rst) begin
      pulses = 0; plen = 0; pmin = 1 << 30; pmax = 0; gmin = 1 << 30;
      gcnt = 0; rises = 0; viol = 0; gap_on = 1'b0; prev_rst = 1'b0; prev_sck = 1'b0;
    end else begin
      if (tgt_rst) plen++;
      if (tgt_rst && sck) viol++;
      if (prev_rst && !tgt_rst) begin
        pulses++;
        if (plen < pmin) pmin = plen;
        if (plen > pmax) pmax = plen;
        plen = 0; gap_on = 1'b1; gcnt = 0;
      end
      if (gap_on) begin
        if (sck) begin
          gap_on = 1'b0;
          if (gcnt < gmin) gmin = gcnt;
        end else gcnt++;
      end
      if (sck && !prev_sck) rises++;
      prev_rst = tgt_rst; prev_sck = sck;
    end
  end

  // target model: echoes the previous byte only once enough bad attempts passed
  int bad_cnt, bc, nbytes;
  logic [7:0] rxb, txb;
  logic [7:0] log_b [0:31];
  always @(posedge sck or negedge sck or posedge tgt_rst or posedge rst) begin
    if (rst) begin
      nbytes = 0; bc = 0; rxb = 8'h00; txb = 8'h00; miso <= 1'b0;
    end else if (tgt_rst) begin
      bc = 0; txb = 8'h00; miso <= 1'b0;
    end else if (sck) begin
      rxb = {rxb[6:0], mosi};
      bc++;
      if (bc == 8) begin
        bc = 0;
        if (nbytes < 32) log_b[nbytes] = rxb;
        nbytes++;
        txb = (pulses > bad_cnt) ? rxb : 8'hA5;
      end
    end else begin
      miso <= txb[7];
      txb = {txb[6:0], 1'b0};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int k);
    case (k)
      0: return OP0;
      1: return 8'h53;
      2: return OP2;
      default: return OP3;
    endcase
  endfunction

  task automatic run_case(input int bad);
    int att, p0, r0, w;
    bit exp_done;
    bad_cnt = bad;
    exp_done = (bad < MAX_TRIES);
    att = exp_done ? bad + 1 : MAX_TRIES;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!tgt_rst && !sck && !mosi && !done && !fail, "R1 reset outputs",
          {tgt_rst, sck, mosi, done, fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!tgt_rst && !sck && !done && !fail, "R1 after reset", {tgt_rst, sck, done, fail}, 0);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    w = 0;
    while (!done && !fail && w < 20000) begin
      @(negedge clk);
      w++;
    end
    check(done == exp_done, "R5 done flag", done, exp_done);
    check(fail == !exp_done, "R8 fail flag", fail, !exp_done);
    check(pulses == att, "R7 reset pulses per attempt", pulses, att);
    check(pmin == PULSE_CYC && pmax == PULSE_CYC, "R2 pulse width", pmax, PULSE_CYC);
    check(viol == 0, "R2 sck low during pulse", viol, 0);
    check(gmin >= WAIT_CYC, "R3 settle gap", gmin, WAIT_CYC);
    check(rises == 32 * att, "R6 sck edges per attempt", rises, 32 * att);
    check(nbytes == 4 * att, "R6 bytes sent", nbytes, 4 * att);
    for (int a = 0; a < att; a++)
      for (int k = 0; k < 4; k++)
        check(log_b[4 * a + k] == frame_byte(k), "R4 frame byte MSB first",
              log_b[4 * a + k], frame_byte(k));
    p0 = pulses; r0 = rises;
    repeat (400) @(negedge clk);
    check(pulses == p0 && rises == r0 && !tgt_rst, "R8 quiet after result",
          rises - r0 + pulses - p0, 0);
    check(done == exp_done && fail == !exp_done, "R10 flags held", {done, fail}, {exp_done, !exp_done});
    end_session = 1'b1;
    @(negedge clk) end_session = 1'b0;
    repeat (2) @(negedge clk);
    check(tgt_rst && !sck, "R9 release drives reset high", {tgt_rst, sck}, 2);
    repeat (50) @(negedge clk);
    check(tgt_rst && !sck && rises == r0, "R9 release held", {tgt_rst, sck}, 2);
    check(done == exp_done && fail == !exp_done, "R9 flag kept", {done, fail}, {exp_done, !exp_done});
  endtask

  initial begin
    bad_cnt = 0;
    for (int b = 0; b <= MAX_TRIES + 1; b++) run_case(b);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule